// File: doc/BRIEF.md
# Ethernet Link Clock-Rate Mode Detector

This block tells the surrounding Ethernet logic whether the PHY is running in gigabit byte-wide mode or in the slower nibble-wide mode. It does not read the mode from a register. It measures the PHY receive clock against the system clock, whose frequency is known. A counter in the receive domain splits that clock into windows of a fixed number of cycles. At the end of each window it flips a toggle. The toggle crosses into the system domain through a two-flop synchronizer and an edge detector. A system-domain counter measures how many system cycles each window lasted. The window is classified as gigabit when that count is at or below a threshold, and as nibble mode when it is above it.

The threshold is computed at elaboration time from three values: the system clock rate, the nominal gigabit receive clock rate, and a tolerance margin given in permille. The calculation uses 64-bit arithmetic, so ratios that are not whole numbers are handled exactly. A nibble-mode clock is roughly five times slower than a gigabit clock, so the margin can be made wide (for example 500 permille) without the two cases overlapping. The system-domain counter saturates. If the receive clock stops, the block falls back to nibble mode instead of freezing with a stale decision.

Top module: `eth_speed_detect`

## Requirements
- R1: While either reset is held and after it is released, `mode_gig` is 0 (nibble mode) and `mode_upd` is 0 until the first decision.
- R2: With a 100 MHz system clock and a 125 MHz receive clock, each decision sets `mode_gig` to 1.
- R3: With a 100 MHz system clock and a 25 MHz receive clock, each decision sets `mode_gig` to 0.
- R4: The threshold is floor(SYS_CLK_HZ × WIN_LEN × (1000 + MARGIN_PERMILLE) / (REF_HZ × 1000)). This is 860 with the defaults (100 MHz, 125 MHz, 1024, 50). A window whose system-cycle count is at or below the threshold selects gigabit, and one above it selects nibble. So an 8.2 ns receive period gives 1 and an 8.8 ns period gives 0.
- R5: `mode_upd` is a single-cycle pulse issued once per completed window. The strobes are spaced by the window duration in system cycles. `mode_gig` changes only in a cycle where `mode_upd` is 1, and in that cycle it already shows the new decision.
- R6: After reset, and after `enable` rises, the first window edge only starts a measurement. The first decision comes at the end of the first complete window, which is the second window edge.
- R7: While `enable` is 0, no strobe is issued and `mode_gig` holds its value whatever the receive clock does.
- R8: The system-domain counter saturates at 2^CNT_W − 1 (8191 by default). If it reaches that value with no window edge, the block issues a strobe with `mode_gig` = 0 and starts timing again.
- R9: When the receive clock rate changes at run time, `mode_gig` follows the new rate within two decisions.
- R10: Each receive-domain window end produces exactly one single-cycle pulse in the system domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | PHY receive clock being measured |
| rx_rst_n | input | 1 | Synchronous active-low reset, receive domain |
| sys_clk | input | 1 | Reference system clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| enable | input | 1 | Detection enable, system domain |
| mode_gig | output | 1 | 1 = gigabit byte-wide mode, 0 = nibble mode |
| mode_upd | output | 1 | One-cycle strobe marking a registered decision |

## Verification
A decision is due two to four system cycles after the receive-domain toggle flips. The synchronizer and edge detector take about three cycles, and the registered mode and strobe take one more, so the time between strobes equals the window length in system cycles: 819–820 at 125 MHz and 4096 at 25 MHz. The first strobe after reset is due at about 1640 cycles, at the end of the second window. A stall strobe is due 8192 cycles after the previous clear. The bench never checks at a fixed edge. Its monitor samples `mode_gig` on the falling edge of every strobe and compares it with the expected mode queued by the driver. The driver lets two strobes pass after every clock change, because the window that straddles the change is ambiguous. Strobe spacing and the time of the first strobe are checked against windows of a few cycles around these figures.

// File: rtl/eth_speed_pkg.sv
// Package: shared types for the link clock-rate mode detector.
// Assumes: nothing beyond IEEE 1800-2017.
package eth_speed_pkg;

    // Detector sequencing states.
    typedef enum logic [1:0] {
        DET_IDLE = 2'd0,   // disabled, counter held clear
        DET_ARM  = 2'd1,   // waiting for a window edge to start timing
        DET_RUN  = 2'd2    // timing windows and deciding
    } det_state_e;

    localparam logic MODE_NIBBLE = 1'b0;
    localparam logic MODE_GIG    = 1'b1;

    // Elaboration-time threshold in system cycles, 64-bit exact floor.
    function automatic longint unsigned calc_thresh(
        input longint unsigned sys_hz,
        input longint unsigned ref_hz,
        input longint unsigned win_len,
        input longint unsigned margin_pm
    );
        return (sys_hz * win_len * (64'd1000 + margin_pm)) / (ref_hz * 64'd1000);
    endfunction

endpackage

// File: rtl/rx_window_gen.sv
// Module: rx_window_gen
// Divides the receive clock into windows of WIN_LEN cycles and flips a
// toggle at the end of each one. The toggle is the only signal that
// leaves this domain. Assumes WIN_LEN >= 2.
module rx_window_gen #(
    parameter int WIN_LEN = 1024
) (
    input  logic rx_clk,
    input  logic rx_rst_n,
    output logic win_tog
);
    localparam int W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [W-1:0] LAST = W'(WIN_LEN - 1);

    logic [W-1:0] cyc_cnt;

    // Count receive cycles and flip the toggle on each window wrap.
    always_ff @(posedge rx_clk) begin
        if (!rx_rst_n) begin
            cyc_cnt <= '0;
            win_tog <= 1'b0;
        end else if (cyc_cnt == LAST) begin
            cyc_cnt <= '0;
            win_tog <= ~win_tog;
        end else begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    AST_TOG_AT_WRAP: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (win_tog != $past(win_tog)) |-> ($past(cyc_cnt) == LAST)); // R10

endmodule

// File: rtl/tog_pulse_sync.sv
// Module: tog_pulse_sync
// Carries a toggle from a foreign domain into the system domain through
// two flops, then turns each edge into a one-cycle pulse. Assumes the
// toggle changes far less often than once every three system cycles.
module tog_pulse_sync (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic meta_q, sync_q, hist_q;

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= tog_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // A toggle edge of either polarity is one window end.
    always_comb pulse = sync_q ^ hist_q;

    AST_PULSE_SINGLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        pulse |=> !pulse); // R10

endmodule

// File: rtl/sys_window_timer.sv
// Module: sys_window_timer
// Counts system cycles since the last clear and saturates at the top
// value. Assumes the clear is issued by the decision logic.
module sys_window_timer #(
    parameter int CNT_W = 13
) (
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             sat
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_comb sat = (cnt == TOP);

    // Clear on request, otherwise count up and stop at the top.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n || clr) begin
            cnt <= '0;
        end else if (!sat) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_NO_WRAP: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (sat && !clr) |=> sat); // R8

endmodule

// File: rtl/mode_decide_fsm.sv
// Module: mode_decide_fsm
// Sequences the measurement and registers the decisions. The first window
// edge after reset or enable only starts timing. Each later edge compares
// the count with THRESH. Reaching saturation with no edge forces nibble mode.
module mode_decide_fsm
    import eth_speed_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter logic [CNT_W-1:0] THRESH = '0
) (
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic             enable,
    input  logic             win_pulse,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_sat,
    output logic             cnt_clr,
    output logic             mode_gig,
    output logic             mode_upd
);
    det_state_e state_q, state_d;
    logic decide, stall;

    // A decision is made at a window edge, or when timing stalls at saturation.
    always_comb begin
        decide  = enable && (state_q == DET_RUN) && win_pulse;
        stall   = enable && (state_q == DET_RUN) && !win_pulse && cnt_sat;
        cnt_clr = (state_q != DET_RUN) || !enable || win_pulse || stall;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = DET_IDLE;
        end else begin
            case (state_q)
                DET_IDLE: state_d = DET_ARM;
                DET_ARM:  if (win_pulse) state_d = DET_RUN;
                DET_RUN:  state_d = DET_RUN;
                default:  state_d = DET_IDLE;
            endcase
        end
    end

    // State, registered mode and update strobe.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            state_q  <= DET_IDLE;
            mode_gig <= MODE_NIBBLE;
            mode_upd <= 1'b0;
        end else begin
            state_q  <= state_d;
            mode_upd <= decide || stall;
            if (decide) begin
                mode_gig <= (cnt <= THRESH) ? MODE_GIG : MODE_NIBBLE;
            end else if (stall) begin
                mode_gig <= MODE_NIBBLE;
            end
        end
    end

    AST_MODE_ONLY_ON_UPD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !mode_upd |-> $stable(mode_gig)); // R5
    AST_UPD_SINGLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        mode_upd |=> !mode_upd); // R5
    AST_QUIET_DISABLED: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !enable |=> !mode_upd); // R7
    AST_STALL_NIBBLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (enable && state_q == DET_RUN && cnt_sat && !win_pulse) |=> (mode_upd && !mode_gig)); // R8
    AST_ARM_NO_UPD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (state_q != DET_RUN) |=> !mode_upd); // R6

endmodule

// File: rtl/eth_speed_detect.sv
// Module: eth_speed_detect (top)
// Classifies the PHY receive clock as gigabit or nibble rate by timing
// fixed receive-clock windows against the system clock.
// Assumes: SYS_CLK_HZ, REF_HZ fit in 32 bits; both resets are synchronous
// active-low in their own domains.
module eth_speed_detect
    import eth_speed_pkg::*;
#(
    parameter int SYS_CLK_HZ      = 100_000_000,
    parameter int REF_HZ          = 125_000_000,
    parameter int WIN_LEN         = 1024,
    parameter int MARGIN_PERMILLE = 50
) (
    input  logic rx_clk,
    input  logic rx_rst_n,
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic enable,
    output logic mode_gig,
    output logic mode_upd
);
    localparam longint unsigned THRESH_L = calc_thresh(
        longint'(SYS_CLK_HZ), longint'(REF_HZ), longint'(WIN_LEN), longint'(MARGIN_PERMILLE));
    localparam int THRESH_I = int'(THRESH_L);
    // Counter range covers eight thresholds, so slow links still fit.
    localparam int CNT_W = $clog2(THRESH_I * 8 + 1);
    localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(THRESH_I);

    logic             win_tog;
    logic             win_pulse;
    logic             cnt_clr;
    logic             cnt_sat;
    logic [CNT_W-1:0] cnt;

    rx_window_gen #(.WIN_LEN(WIN_LEN)) u_win (
        .rx_clk   (rx_clk),
        .rx_rst_n (rx_rst_n),
        .win_tog  (win_tog)
    );

    tog_pulse_sync u_sync (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .tog_in    (win_tog),
        .pulse     (win_pulse)
    );

    sys_window_timer #(.CNT_W(CNT_W)) u_timer (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .clr       (cnt_clr),
        .cnt       (cnt),
        .sat       (cnt_sat)
    );

    mode_decide_fsm #(.CNT_W(CNT_W), .THRESH(THRESH_V)) u_fsm (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .enable    (enable),
        .win_pulse (win_pulse),
        .cnt       (cnt),
        .cnt_sat   (cnt_sat),
        .cnt_clr   (cnt_clr),
        .mode_gig  (mode_gig),
        .mode_upd  (mode_upd)
    );

    AST_RESET_NIBBLE: assert property (@(posedge sys_clk)
        $past(!sys_rst_n) |-> (!mode_gig && !mode_upd)); // R1

endmodule

// File: tb/eth_speed_detect_tb.sv
`timescale 1ns/1ps
module eth_speed_detect_tb;

    logic sys_clk = 1'b0;
    logic rx_clk  = 1'b0;
    logic sys_rst_n = 1'b0;
    logic rx_rst_n  = 1'b0;
    logic enable    = 1'b0;
    logic mode_gig, mode_upd;

    real  rx_half = 4.0;
    bit   rx_run  = 1'b1;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int n_upd = 0;
    int last_upd_cyc = 0;
    int last_gap = 0;
    int first_upd_cyc = -1;
    bit done = 1'b0;

    bit    exp_q[$];
    string exp_tag[$];

    eth_speed_detect u_dut (
        .rx_clk    (rx_clk),
        .rx_rst_n  (rx_rst_n),
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .enable    (enable),
        .mode_gig  (mode_gig),
        .mode_upd  (mode_upd)
    );

    always #5 sys_clk = ~sys_clk;

    always begin
        if (rx_run) #(rx_half) rx_clk = ~rx_clk;
        else #1;
    end

    always @(posedge sys_clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // Monitor: on each strobe, record spacing and compare with the queue head.
    always @(negedge sys_clk) begin
        if (sys_rst_n && mode_upd) begin
            n_upd++;
            last_gap = cyc - last_upd_cyc;
            last_upd_cyc = cyc;
            if (first_upd_cyc < 0) first_upd_cyc = cyc;
            if (exp_q.size() > 0) begin
                automatic bit e = exp_q.pop_front();
                automatic string t = exp_tag.pop_front();
                check(t, int'(mode_gig), int'(e), int'(e));
            end
        end
    end

    task automatic wait_upd(input int k);
        int s = n_upd;
        while (n_upd < s + k) @(negedge sys_clk);
    endtask

    // Driver: queue expected modes, then wait until they are all consumed.
    task automatic expect_mode(input bit m, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(m);
            exp_tag.push_back(req);
        end
        while (exp_q.size() > 0) @(negedge sys_clk);
    endtask

    task automatic set_rx(input real half);
        rx_half = half;
        wait_upd(2);
    endtask

    initial begin
        int s;
        repeat (10) @(negedge sys_clk);
        check("R1 mode in reset", int'(mode_gig), 0, 0);
        check("R1 upd in reset", int'(mode_upd), 0, 0);
        sys_rst_n = 1'b1;
        rx_rst_n  = 1'b1;
        enable    = 1'b1;
        s = cyc;
        repeat (20) @(negedge sys_clk);
        check("R1 mode after reset", int'(mode_gig), 0, 0);

        // R2 and R6: the first strobe comes at the end of the second window.
        expect_mode(1'b1, 3, "R2 gigabit 125MHz");
        check("R6 first decision cycle", first_upd_cyc - s, 1600, 1700);
        check("R5 gap at 125MHz", last_gap, 817, 822);

        // R3 and R9: run-time switch to 25 MHz.
        set_rx(20.0);
        expect_mode(1'b0, 3, "R3 nibble 25MHz / R9 switch");
        check("R5 gap at 25MHz", last_gap, 4093, 4099);

        // R4: margin boundary cases.
        set_rx(4.1);
        expect_mode(1'b1, 2, "R4 8.2ns inside margin");
        set_rx(4.4);
        expect_mode(1'b0, 2, "R4 8.8ns beyond margin");

        // R9: back to gigabit.
        set_rx(4.0);
        expect_mode(1'b1, 2, "R9 switch back to gigabit");

        // R7: disabled, change the clock, no strobes, mode held.
        enable = 1'b0;
        s = n_upd;
        rx_half = 20.0;
        repeat (9000) @(negedge sys_clk);
        check("R7 no strobe while disabled", n_upd - s, 0, 0);
        check("R7 mode held while disabled", int'(mode_gig), 1, 1);
        enable = 1'b1;
        s = cyc;
        wait_upd(1);
        check("R6 first decision after enable", cyc - s, 4096, 8200);
        expect_mode(1'b0, 1, "R7 after re-enable");

        // R8: stop the receive clock while in gigabit mode.
        rx_half = 4.0;
        wait_upd(2);
        expect_mode(1'b1, 1, "R8 gigabit before stall");
        repeat (300) @(negedge sys_clk);
        rx_run = 1'b0;
        expect_mode(1'b0, 1, "R8 stall forces nibble");
        check("R8 stall gap", last_gap, 8188, 8196);
        rx_run = 1'b1;
        wait_upd(2);
        expect_mode(1'b1, 2, "R9 recover after stall");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule